// File: doc/BRIEF.md
# Reloading Prescaler with Event Counter

This block divides a tick-enable stream (nominally 20 MHz, synchronous to the block clock) by a programmable amount. A down-counting prescale register steps once per tick. When it is already at zero, the next tick refills it from a reload register, and the same tick advances a separate event counter. With a reload value of R, one prescale period therefore lasts R+1 ticks.

Software reaches all three registers through one write strobe and one data bus each, and reads their current values back on dedicated outputs. Address decoding is left to the surrounding register bank. Each register can be written on its own. A write to the prescale count or the event counter wins over a tick-driven update in the same cycle.

Top module: `reload_prescaler`

## Requirements
- R1: After reset, the reload value, the prescale count and the event counter all read zero.
- R2: On a tick, a nonzero prescale count drops by one. In a cycle with no tick and no write, the prescale count and the event counter keep their values.
- R3: On a tick with the prescale count at zero, the count is loaded with the reload value and the event counter rises by one in that same cycle. With reload R > 0, this gives one event every R+1 ticks.
- R4: With a reload value of zero, the prescale count stays at zero and the event counter rises on every tick.
- R5: A prescale count written above the reload value counts down from the written value before its first reload. From 7 with reload 5, the sequence is 7,6,5,4,3,2,1,0,5,4,3,2,1,0,5.
- R6: Writing the reload value leaves the current prescale count unchanged. The new value is used at the next reload. A reload in the same cycle as a reload write uses the previous reload value.
- R7: A write to the prescale count takes priority over any tick update of the count. A write to the event counter takes priority over an increment in the same cycle.
- R8: The event counter wraps from its all-ones value to zero.
- R9: A written value appears on the matching read output in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler tick enable |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_wdata | input | PS_W | New reload value |
| count_we | input | 1 | Write strobe for the prescale count |
| count_wdata | input | PS_W | New prescale count |
| events_we | input | 1 | Write strobe for the event counter |
| events_wdata | input | EV_W | New event counter value |
| reload_q | output | PS_W | Current reload value |
| count_q | output | PS_W | Current prescale count |
| events_q | output | EV_W | Current event counter |

## Verification
The bench sweeps every reload value from 0 to 5 against every starting count from 0 to 7, under an irregular tick pattern. Its cycle-accurate model of the counter catches three kinds of fault: a design that reloads directly on reaching zero (periods of R ticks instead of R+1), one that treats a zero reload as a stall or a wrap to all-ones, and one that clamps a written count to the reload value. Same-cycle collisions are driven on purpose: reload write against a reload, count write against a tick, and event write against an increment. A design with the wrong priority or an early reload shows a count or event value that is off by one period. The all-ones event value is written and then ticked, to catch a counter that saturates or raises a flag instead of wrapping.

// File: rtl/rp_pkg.sv
package rp_pkg;

   // Next-state choice of the prescale count register
   typedef enum logic [1:0] {
      PS_HOLD   = 2'd0,
      PS_DEC    = 2'd1,
      PS_RELOAD = 2'd2,
      PS_LOAD   = 2'd3
   } ps_action_e;

   // Next-state choice of the event counter
   typedef enum logic [1:0] {
      EV_HOLD = 2'd0,
      EV_INC  = 2'd1,
      EV_LOAD = 2'd2
   } ev_action_e;

   localparam int unsigned RP_MAX_W = 64;

endpackage

// File: rtl/rp_reload_reg.sv
module rp_reload_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] value
);

   logic [W-1:0] value_r;

   always_ff @(posedge clk) begin
      if (!rst_n)
         value_r <= '0;
      else if (we)
         value_r <= wdata;
   end

   assign value = value_r;

endmodule

// File: rtl/rp_down_counter.sv
module rp_down_counter
   import rp_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] reload_val,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] count,
   output logic         period_done
);

   logic [W-1:0] count_r;
   logic         at_zero;
   ps_action_e   action;

   assign at_zero     = (count_r == '0);
   assign period_done = tick & at_zero;

   always_comb begin
      if (wr_en)
         action = PS_LOAD;
      else if (tick && at_zero)
         action = PS_RELOAD;
      else if (tick)
         action = PS_DEC;
      else
         action = PS_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_r <= '0;
      end else begin
         unique case (action)
            PS_LOAD:   count_r <= wr_data;
            PS_RELOAD: count_r <= reload_val;
            PS_DEC:    count_r <= count_r - {{(W-1){1'b0}}, 1'b1};
            default:   count_r <= count_r;
         endcase
      end
   end

   assign count = count_r;

endmodule

// File: rtl/rp_event_counter.sv
module rp_event_counter
   import rp_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] value
);

   logic [W-1:0] value_r;
   ev_action_e   action;

   always_comb begin
      if (wr_en)
         action = EV_LOAD;
      else if (inc)
         action = EV_INC;
      else
         action = EV_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value_r <= '0;
      end else begin
         unique case (action)
            EV_LOAD: value_r <= wr_data;
            EV_INC:  value_r <= value_r + {{(W-1){1'b0}}, 1'b1};
            default: value_r <= value_r;
         endcase
      end
   end

   assign value = value_r;

endmodule

// File: rtl/reload_prescaler.sv
module reload_prescaler
   import rp_pkg::*;
#(
   parameter int unsigned PS_W = 32,
   parameter int unsigned EV_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            reload_we,
   input  logic [PS_W-1:0] reload_wdata,
   input  logic            count_we,
   input  logic [PS_W-1:0] count_wdata,
   input  logic            events_we,
   input  logic [EV_W-1:0] events_wdata,
   output logic [PS_W-1:0] reload_q,
   output logic [PS_W-1:0] count_q,
   output logic [EV_W-1:0] events_q
);

   generate
      if (PS_W < 1 || PS_W > RP_MAX_W) begin : g_bad_ps_w
         $error("reload_prescaler: PS_W out of range");
      end
      if (EV_W < 1 || EV_W > RP_MAX_W) begin : g_bad_ev_w
         $error("reload_prescaler: EV_W out of range");
      end
   endgenerate

   logic [PS_W-1:0] reload_val;
   logic            period_done;

   rp_reload_reg #(.W(PS_W)) u_reload (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reload_we),
      .wdata (reload_wdata),
      .value (reload_val)
   );

   rp_down_counter #(.W(PS_W)) u_pscount (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .reload_val  (reload_val),
      .wr_en       (count_we),
      .wr_data     (count_wdata),
      .count       (count_q),
      .period_done (period_done)
   );

   rp_event_counter #(.W(EV_W)) u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (period_done),
      .wr_en   (events_we),
      .wr_data (events_wdata),
      .value   (events_q)
   );

   assign reload_q = reload_val;

endmodule

// File: rtl/rp_checker.sv
module rp_checker #(
   parameter int unsigned PS_W = 32,
   parameter int unsigned EV_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tick,
   input logic            reload_we,
   input logic [PS_W-1:0] reload_wdata,
   input logic            count_we,
   input logic [PS_W-1:0] count_wdata,
   input logic            events_we,
   input logic [EV_W-1:0] events_wdata,
   input logic [PS_W-1:0] reload_q,
   input logic [PS_W-1:0] count_q,
   input logic [EV_W-1:0] events_q
);

   // R2
   a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !count_we && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

   // R2
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !count_we && !events_we) |=> ($stable(count_q) && $stable(events_q)));

   // R3, R6: reload uses the value held before the edge
   a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !count_we && count_q == '0) |=> count_q == $past(reload_q));

   // R3, R8
   a_r3_event_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !events_we && count_q == '0) |=> events_q == $past(events_q) + 1'b1);

   // R3
   a_r3_no_stray_event: assert property (@(posedge clk) disable iff (!rst_n)
      (!events_we && !(tick && count_q == '0)) |=> $stable(events_q));

   // R7, R9
   a_r7_count_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      count_we |=> count_q == $past(count_wdata));

   // R7, R9
   a_r7_event_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      events_we |=> events_q == $past(events_wdata));

   // R9
   a_r9_reload_write: assert property (@(posedge clk) disable iff (!rst_n)
      reload_we |=> reload_q == $past(reload_wdata));

   // R6
   a_r6_reload_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reload_we |=> $stable(reload_q));

endmodule

bind reload_prescaler rp_checker #(.PS_W(PS_W), .EV_W(EV_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick         (tick),
   .reload_we    (reload_we),
   .reload_wdata (reload_wdata),
   .count_we     (count_we),
   .count_wdata  (count_wdata),
   .events_we    (events_we),
   .events_wdata (events_wdata),
   .reload_q     (reload_q),
   .count_q      (count_q),
   .events_q     (events_q)
);

// File: tb/sim_reload_prescaler.sv
`timescale 1ns/1ps
module sim_reload_prescaler;

   localparam int PS_W = 32;
   localparam int EV_W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tick = 1'b0;
   logic            reload_we = 1'b0;
   logic [PS_W-1:0] reload_wdata = '0;
   logic            count_we = 1'b0;
   logic [PS_W-1:0] count_wdata = '0;
   logic            events_we = 1'b0;
   logic [EV_W-1:0] events_wdata = '0;
   logic [PS_W-1:0] reload_q;
   logic [PS_W-1:0] count_q;
   logic [EV_W-1:0] events_q;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference state
   logic [PS_W-1:0] m_rel;
   logic [PS_W-1:0] m_cnt;
   logic [EV_W-1:0] m_ev;

   always #4 clk = ~clk;

   reload_prescaler #(.PS_W(PS_W), .EV_W(EV_W)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .reload_we(reload_we), .reload_wdata(reload_wdata),
      .count_we(count_we), .count_wdata(count_wdata),
      .events_we(events_we), .events_wdata(events_wdata),
      .reload_q(reload_q), .count_q(count_q), .events_q(events_q)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string req);
      check(req, "reload", 64'(reload_q), 64'(m_rel));
      check(req, "count",  64'(count_q),  64'(m_cnt));
      check(req, "events", 64'(events_q), 64'(m_ev));
   endtask

   // One cycle: inputs driven now (away from the edge), model advanced,
   // outputs compared 1 ns after the edge, then back to the falling edge.
   task automatic step(input string req, input bit t,
                       input bit rw, input logic [PS_W-1:0] rd,
                       input bit cw, input logic [PS_W-1:0] cd,
                       input bit ew, input logic [EV_W-1:0] ed);
      logic [PS_W-1:0] n_cnt;
      logic [EV_W-1:0] n_ev;
      tick = t; reload_we = rw; reload_wdata = rd;
      count_we = cw; count_wdata = cd; events_we = ew; events_wdata = ed;
      n_cnt = m_cnt;
      n_ev  = m_ev;
      if (t) begin
         if (m_cnt == '0) begin
            n_cnt = m_rel;
            n_ev  = m_ev + 1'b1;
         end else begin
            n_cnt = m_cnt - 1'b1;
         end
      end
      if (cw) n_cnt = cd;
      if (ew) n_ev = ed;
      if (rw) m_rel = rd;
      m_cnt = n_cnt;
      m_ev  = n_ev;
      @(posedge clk);
      #1;
      check_all(req);
      @(negedge clk);
      tick = 1'b0; reload_we = 1'b0; count_we = 1'b0; events_we = 1'b0;
   endtask

   task automatic tk(input string req);
      step(req, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, '0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stim
      m_rel = '0; m_cnt = '0; m_ev = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);

      // R2: idle cycles hold
      m_cnt = 32'd3;
      step("R9", 1'b0, 1'b0, '0, 1'b1, 32'd3, 1'b0, '0);
      repeat (3) step("R2", 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
      m_cnt = 32'd3;
      tk("R2");
      tk("R2");

      // R5: 7 with reload 5, exact sequence and two events
      step("R9", 1'b0, 1'b1, 32'd5, 1'b1, 32'd7, 1'b1, 32'd0);
      for (int i = 0; i < 14; i++) tk("R5");
      check("R5", "count after 14 ticks", 64'(count_q), 64'd5);
      check("R5", "events after 14 ticks", 64'(events_q), 64'd2);

      // R4: zero reload sticks, event each tick
      step("R4", 1'b0, 1'b1, 32'd0, 1'b1, 32'd1, 1'b1, 32'd0);
      for (int i = 0; i < 6; i++) tk("R4");
      check("R4", "events after stick", 64'(events_q), 64'd5);
      check("R4", "count stuck", 64'(count_q), 64'd0);

      // Sweep R3/R4/R5: reload 0..5 x start 0..7, irregular ticks
      for (int r = 0; r < 6; r++) begin
         for (int s = 0; s < 8; s++) begin
            step("R3", 1'b0, 1'b1, 32'(r), 1'b1, 32'(s), 1'b1, 32'd0);
            for (int c = 0; c < 30; c++)
               step((r == 0) ? "R4" : ((s > r) ? "R5" : "R3"),
                    ((c % 4) != 3), 1'b0, '0, 1'b0, '0, 1'b0, '0);
         end
      end

      // R6: reload write does not touch count; collision uses old value
      step("R6", 1'b0, 1'b1, 32'd2, 1'b1, 32'd1, 1'b0, '0);
      step("R6", 1'b1, 1'b1, 32'd9, 1'b0, '0, 1'b0, '0);  // 1 -> 0
      check("R6", "count after reload write", 64'(count_q), 64'd0);
      step("R6", 1'b1, 1'b1, 32'd4, 1'b0, '0, 1'b0, '0);  // reload with 9
      check("R6", "old reload used", 64'(count_q), 64'd9);
      check("R6", "new reload stored", 64'(reload_q), 64'd4);

      // R7: count write beats tick, event write beats increment
      step("R7", 1'b0, 1'b0, '0, 1'b1, 32'd0, 1'b0, '0);
      step("R7", 1'b1, 1'b0, '0, 1'b1, 32'd6, 1'b1, 32'h55);
      check("R7", "count write wins", 64'(count_q), 64'd6);
      check("R7", "event write wins", 64'(events_q), 64'h55);
      step("R7", 1'b1, 1'b0, '0, 1'b1, 32'd0, 1'b0, '0);
      check("R7", "count write over decrement", 64'(count_q), 64'd0);

      // R8: wrap from all-ones
      step("R8", 1'b0, 1'b0, '0, 1'b0, '0, 1'b1, 32'hFFFF_FFFF);
      tk("R8");
      check("R8", "events wrapped", 64'(events_q), 64'd0);
      for (int i = 0; i < 5; i++) tk("R8");

      // R1: reset again in mid-run
      rst_n = 1'b0;
      @(posedge clk); #1;
      m_rel = '0; m_cnt = '0; m_ev = '0;
      check_all("R1");
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule